// File: doc/BRIEF.md
# Segment Selector Load Checker

This block runs the validation that follows a write of a 16-bit selector into a segment register. It splits the selector into a descriptor index, a table-select bit and a requested privilege level. It then picks the global or the local descriptor table and checks that the whole 8-byte entry lies inside that table's limit. If it does, the block fetches the entry as two 32-bit reads over a valid/ready memory port.

The fetched descriptor is judged against the kind of register being loaded. A data register, the stack register and the code register each accept different descriptor classes, types and privilege relations. A load that passes writes the descriptor and the selector into that register's shadow slot and pulses `done`. A load that fails leaves every shadow slot untouched and pulses `fault` with a vector number and an error code.

The surrounding pipeline raises `req_valid` with the selector and a slot number while `busy` is low. It holds both table descriptions steady until the outcome pulse.

Top module: `seg_sel_loader`

## Requirements
- R1: The selector is read as index = bits 15:3, table select = bit 2 (0 global, 1 local) and RPL = bits 1:0. The entry is fetched at the chosen table base plus index*8 as the low 32-bit word, then at that address plus 4 as the high word.
- R2: If index*8+7 is greater than the chosen table limit, the load faults with vector 13 one cycle after acceptance and issues no memory read.
- R3: A global selector with index 0 (any RPL) issues no read. For a data slot it completes with that slot's usable flag cleared and its descriptor cleared. For the stack or code slot it faults with vector 13 and error code 0.
- R4: A descriptor whose bit 44 is 0 (a system descriptor) faults with vector 13.
- R5: The type field is descriptor bits 43:40, where bit 43 is executable and bit 41 is readable (code) or writable (data). Slot 1 (stack) needs a non-executable, writable segment. Slot 2 (code) needs an executable segment. Slots 0 and 3 (data) reject an executable segment that is not readable. Any violation faults with vector 13.
- R6: The descriptor privilege level is bits 46:45. A data slot faults with vector 13 when DPL < RPL. The stack slot faults with vector 13 when DPL differs from RPL. The code slot makes no privilege check.
- R7: If the class, type and privilege checks pass but the present bit (bit 47) is clear, the load faults with vector 11.
- R8: Each accepted load yields exactly one single-cycle pulse of either `done` or `fault`, never both. `busy` is high from acceptance until that pulse, and `req_valid` is ignored while busy.
- R9: On `done`, the target slot's shadow receives the 64-bit descriptor, the selector, and usable = 1 (except as in R3). No other slot changes, and a fault changes no slot.
- R10: The fault error code carries the selector index in bits 15:3 and the table select in bit 2, with bits 1:0 zero.
- R11: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a load (taken when not busy) |
| req_sel | input | 16 | Selector being loaded |
| req_slot | input | 2 | Target: 0/3 data, 1 stack, 2 code |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | 16 | Global table limit (size in bytes minus one) |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | 16 | Local table limit |
| busy | output | 1 | Load in progress |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_vec | output | 8 | Fault vector (13 or 11) |
| fault_code | output | 16 | Fault error code |
| shadow_sel | output | 4*16 | Per-slot loaded selector, slot 0 lowest |
| shadow_desc | output | 4*64 | Per-slot cached descriptor, slot 0 lowest |
| shadow_usable | output | 4 | Per-slot usable flag |

## Verification
The bench builds the block with the default ADDR_W of 32. It places an eight-entry global table and a four-entry local table at distinct bases, so index 8 of the global table and index 4 of the local table sit exactly one entry past their limits. That layout reaches the table-select path, the limit boundary on both tables, the null entry in every slot kind, and each fault class, all with real 32-bit addresses. The memory responder stalls `mem_rd_ready` on a repeating pattern and varies the response delay. This exercises the held-request rule and the two-word ordering.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;

    localparam int SEL_W     = 16;
    localparam int IDX_W     = 13;
    localparam int WORD_W    = 32;
    localparam int DESC_W    = 2 * WORD_W;
    localparam int SLOT_W    = 2;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_NP = 8'd11;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_DATA_A = 2'd0,
        SLOT_STACK  = 2'd1,
        SLOT_CODE   = 2'd2,
        SLOT_DATA_B = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_RLO, ST_WLO, ST_RHI, ST_WHI
    } ld_state_e;

    typedef enum logic [1:0] {
        VERD_OK, VERD_GP, VERD_NP
    } verdict_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ti;
        logic [1:0]       rpl;
    } sel_t;

    typedef struct packed {
        logic [7:0]  base_hi;
        logic [3:0]  flags;
        logic [3:0]  lim_hi;
        logic        present;
        logic [1:0]  dpl;
        logic        app;
        logic [3:0]  typ;
        logic [23:0] base_lo;
        logic [15:0] lim_lo;
    } desc_t;

    function automatic logic [SEL_W-1:0] err_code(sel_t s);
        return {s.idx, s.ti, 2'b00};
    endfunction

    function automatic logic slot_is_data(slot_e s);
        return (s == SLOT_DATA_A) || (s == SLOT_DATA_B);
    endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode
    import seg_ld_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  sel_t              sel,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [15:0]       ldt_limit,
    output logic              is_null,
    output logic              in_limit,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [15:0]       last_byte;
    logic [15:0]       limit;
    logic [ADDR_W-1:0] base;

    always_comb begin
        last_byte  = {sel.idx, 3'b111};
        limit      = sel.ti ? ldt_limit : gdt_limit;
        base       = sel.ti ? ldt_base : gdt_base;
        is_null    = !sel.ti && (sel.idx == '0);
        in_limit   = last_byte <= limit;
        entry_addr = base + ADDR_W'({sel.idx, 3'b000});
    end
endmodule

// File: rtl/desc_check.sv
module desc_check
    import seg_ld_pkg::*;
(
    input  slot_e      slot,
    input  logic [1:0] rpl,
    input  logic       app,
    input  logic       present,
    input  logic [1:0] dpl,
    input  logic       exec,
    input  logic       rw,
    output verdict_e   verdict
);
    logic type_ok;
    logic priv_ok;

    always_comb begin
        unique case (slot)
            SLOT_STACK: begin
                type_ok = !exec && rw;
                priv_ok = (dpl == rpl);
            end
            SLOT_CODE: begin
                type_ok = exec;
                priv_ok = 1'b1;
            end
            default: begin
                type_ok = !exec || rw;
                priv_ok = (dpl >= rpl);
            end
        endcase

        if (!app || !type_ok || !priv_ok) verdict = VERD_GP;
        else if (!present)                verdict = VERD_NP;
        else                              verdict = VERD_OK;
    end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import seg_ld_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  slot_e                       wr_slot,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [DESC_W-1:0]           wr_desc,
    input  logic                        wr_usable,
    output logic [NUM_SLOTS*SEL_W-1:0]  sel_flat,
    output logic [NUM_SLOTS*DESC_W-1:0] desc_flat,
    output logic [NUM_SLOTS-1:0]        usable
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == slot_e'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_flat[g*SEL_W +: SEL_W]    <= '0;
                desc_flat[g*DESC_W +: DESC_W] <= '0;
                usable[g]                     <= 1'b0;
            end else if (hit) begin
                sel_flat[g*SEL_W +: SEL_W]    <= wr_sel;
                desc_flat[g*DESC_W +: DESC_W] <= wr_desc;
                usable[g]                     <= wr_usable;
            end
        end
    end
endmodule

// File: rtl/seg_sel_loader.sv
module seg_sel_loader
    import seg_ld_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [15:0]                 req_sel,
    input  logic [1:0]                  req_slot,
    input  logic [ADDR_W-1:0]           gdt_base,
    input  logic [15:0]                 gdt_limit,
    input  logic [ADDR_W-1:0]           ldt_base,
    input  logic [15:0]                 ldt_limit,
    output logic                        busy,
    output logic                        mem_rd_valid,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    input  logic                        mem_rd_ready,
    input  logic                        mem_rsp_valid,
    input  logic [31:0]                 mem_rsp_data,
    output logic                        done,
    output logic                        fault,
    output logic [7:0]                  fault_vec,
    output logic [15:0]                 fault_code,
    output logic [4*16-1:0]             shadow_sel,
    output logic [4*64-1:0]             shadow_desc,
    output logic [3:0]                  shadow_usable
);
    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(WORD_W / 8);

    ld_state_e         st;
    sel_t              sel_q;
    slot_e             slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;
    logic              done_q, fault_q;
    logic [7:0]        vec_q;
    logic [15:0]       code_q;

    logic              is_null, in_limit;
    logic [ADDR_W-1:0] entry_addr;
    desc_t             fetched;
    verdict_e          verdict;
    logic              wr_en, wr_usable;
    logic [DESC_W-1:0] wr_desc;

    sel_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel        (sel_q),
        .gdt_base   (gdt_base),
        .gdt_limit  (gdt_limit),
        .ldt_base   (ldt_base),
        .ldt_limit  (ldt_limit),
        .is_null    (is_null),
        .in_limit   (in_limit),
        .entry_addr (entry_addr)
    );

    assign fetched = desc_t'({mem_rsp_data, lo_q});

    desc_check u_chk (
        .slot    (slot_q),
        .rpl     (sel_q.rpl),
        .app     (fetched.app),
        .present (fetched.present),
        .dpl     (fetched.dpl),
        .exec    (fetched.typ[3]),
        .rw      (fetched.typ[1]),
        .verdict (verdict)
    );

    always_comb begin
        wr_en     = ((st == ST_CHK) && is_null && slot_is_data(slot_q)) ||
                    ((st == ST_WHI) && mem_rsp_valid && (verdict == VERD_OK));
        wr_usable = (st == ST_WHI);
        wr_desc   = (st == ST_WHI) ? DESC_W'(fetched) : '0;
    end

    shadow_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_slot   (slot_q),
        .wr_sel    (sel_q),
        .wr_desc   (wr_desc),
        .wr_usable (wr_usable),
        .sel_flat  (shadow_sel),
        .desc_flat (shadow_desc),
        .usable    (shadow_usable)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sel_q   <= '0;
            slot_q  <= SLOT_DATA_A;
            addr_q  <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            vec_q   <= '0;
            code_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    sel_q  <= sel_t'(req_sel);
                    slot_q <= slot_e'(req_slot);
                    st     <= ST_CHK;
                end
                ST_CHK: begin
                    addr_q <= entry_addr;
                    if (is_null && slot_is_data(slot_q)) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (is_null || !in_limit) begin
                        fault_q <= 1'b1;
                        vec_q   <= VEC_GP;
                        code_q  <= err_code(sel_q);
                        st      <= ST_IDLE;
                    end else begin
                        st <= ST_RLO;
                    end
                end
                ST_RLO: if (mem_rd_ready) st <= ST_WLO;
                ST_WLO: if (mem_rsp_valid) begin
                    lo_q <= mem_rsp_data;
                    st   <= ST_RHI;
                end
                ST_RHI: if (mem_rd_ready) st <= ST_WHI;
                ST_WHI: if (mem_rsp_valid) begin
                    if (verdict == VERD_OK) begin
                        done_q <= 1'b1;
                    end else begin
                        fault_q <= 1'b1;
                        vec_q   <= (verdict == VERD_NP) ? VEC_NP : VEC_GP;
                        code_q  <= err_code(sel_q);
                    end
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (st != ST_IDLE);
    assign mem_rd_valid = (st == ST_RLO) || (st == ST_RHI);
    assign mem_rd_addr  = (st == ST_RHI) ? addr_q + HI_STEP : addr_q;
    assign done         = done_q;
    assign fault        = fault_q;
    assign fault_vec    = vec_q;
    assign fault_code   = code_q;

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
    // R9
    fault_keeps_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(shadow_desc) && $stable(shadow_usable) && $stable(shadow_sel)));
    // R2
    limit_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_CHK) && !in_limit && !is_null) |=> (fault && !mem_rd_valid));
    // R10
    code_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_code[1:0] == 2'b00));
endmodule

// File: tb/seg_sel_loader_bench.sv
module seg_sel_loader_bench;
    localparam logic [31:0] GDT_BASE = 32'h0001_0000;
    localparam logic [31:0] LDT_BASE = 32'h0002_0000;
    localparam logic [15:0] GDT_LIM  = 16'd63;
    localparam logic [15:0] LDT_LIM  = 16'd31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [1:0]  req_slot = '0;
    logic        busy, mem_rd_valid, done, fault;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [7:0]  fault_vec;
    logic [15:0] fault_code;
    logic [63:0]  shadow_sel;
    logic [255:0] shadow_desc;
    logic [3:0]   shadow_usable;

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    logic [31:0] exp_entry = '0;
    logic [63:0] gdt_tab [0:7];
    logic [63:0] ldt_tab [0:3];

    always #5 clk = ~clk;

    seg_sel_loader u_seg_sel_loader (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_slot(req_slot), .gdt_base(GDT_BASE), .gdt_limit(GDT_LIM),
        .ldt_base(LDT_BASE), .ldt_limit(LDT_LIM), .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_vec(fault_vec), .fault_code(fault_code),
        .shadow_sel(shadow_sel), .shadow_desc(shadow_desc),
        .shadow_usable(shadow_usable)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l,
                                       logic [7:0] acc, logic [3:0] fl);
        return {b[31:24], fl, l[19:16], acc, b[23:0], l[15:0]};
    endfunction

    function automatic logic [31:0] fetch_word(logic [31:0] a);
        logic [63:0] d;
        d = 64'hDEAD_BEEF_DEAD_BEEF;
        if (a >= GDT_BASE && a < GDT_BASE + 64) d = gdt_tab[(a - GDT_BASE) >> 3];
        if (a >= LDT_BASE && a < LDT_BASE + 32) d = ldt_tab[(a - LDT_BASE) >> 3];
        return a[2] ? d[63:32] : d[31:0];
    endfunction

    // Behavioural reference: kind 0 = done, 1 = vector 13, 2 = vector 11
    task automatic model(input logic [15:0] s, input logic [1:0] t,
                         output int kind, output logic [63:0] d,
                         output logic usable, output int nr);
        int idx;
        int lim;
        bit is_stack, is_code, exec, rw, type_ok, priv_ok;
        int dpl, rpl;
        idx = int'(s[15:3]);
        rpl = int'(s[1:0]);
        is_stack = (t == 2'd1);
        is_code  = (t == 2'd2);
        d = '0; usable = 1'b0; nr = 0; kind = 1;
        if (!s[2] && idx == 0) begin
            kind = (is_stack || is_code) ? 1 : 0;
            return;
        end
        lim = s[2] ? int'(LDT_LIM) : int'(GDT_LIM);
        if (idx * 8 + 7 > lim) return;
        nr = 2;
        d = s[2] ? ldt_tab[idx] : gdt_tab[idx];
        exec = d[43]; rw = d[41]; dpl = int'(d[46:45]);
        if (is_stack)     begin type_ok = !exec && rw; priv_ok = (dpl == rpl); end
        else if (is_code) begin type_ok = exec;        priv_ok = 1'b1;         end
        else              begin type_ok = !exec || rw; priv_ok = (dpl >= rpl); end
        if (!d[44] || !type_ok || !priv_ok) kind = 1;
        else if (!d[47]) kind = 2;
        else begin kind = 0; usable = 1'b1; end
    endtask

    // Memory responder with stalls and variable latency
    initial begin
        int wait_n = 0;
        int gap = 0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            if (wait_n > 0) begin
                wait_n--;
                if (wait_n == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = fetch_word(a);
                end
            end else if (mem_rd_valid) begin
                gap = (gap + 1) % 3;
                if (gap != 0) begin
                    mem_rd_ready = 1'b1;
                    a = mem_rd_addr;
                    // R1: low word first, then +4
                    chk(mem_rd_addr == exp_entry + (nreads[0] ? 32'd4 : 32'd0), "R1",
                        "read address", {32'd0, mem_rd_addr},
                        {32'd0, exp_entry + (nreads[0] ? 32'd4 : 32'd0)});
                    nreads++;
                    wait_n = 1 + (nreads % 3);
                end
            end
        end
    end

    // Per-clock comparison of the outcome pins
    always @(negedge clk) begin
        if (!rst) chk(!(done && fault), "R8", "done and fault together",
                      {62'd0, done, fault}, 64'd0);
    end

    task automatic run(input logic [15:0] s, input logic [1:0] t, input bit junk,
                       input string tag);
        int kind, enr, cyc;
        logic [63:0] ed;
        logic eu;
        bit got;
        logic [63:0]  pre_sel;
        logic [255:0] pre_desc;
        logic [3:0]   pre_use;
        model(s, t, kind, ed, eu, enr);
        pre_sel = shadow_sel; pre_desc = shadow_desc; pre_use = shadow_usable;
        exp_entry = (s[2] ? LDT_BASE : GDT_BASE) + {16'd0, s[15:3], 3'b000};
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_slot = t;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R8", {tag, " busy after accept"}, {63'd0, busy}, 64'd1);
        cyc = 0; got = 0;
        while (!got && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (junk && cyc == 1) begin
                req_valid = 1'b1; req_sel = 16'h0008; req_slot = 2'd2;
            end else req_valid = 1'b0;
            if (done || fault) got = 1;
        end
        req_valid = 1'b0;
        chk(got, "R8", {tag, " outcome pulse"}, {63'd0, got}, 64'd1);
        chk(done == (kind == 0), "R8", {tag, " done"}, {63'd0, done}, {63'd0, kind == 0});
        if (kind != 0) begin
            chk(fault_vec == ((kind == 2) ? 8'd11 : 8'd13), (kind == 2) ? "R7" : "R4",
                {tag, " vector"}, {56'd0, fault_vec}, (kind == 2) ? 64'd11 : 64'd13);
            chk(fault_code == {s[15:2], 2'b00}, "R10", {tag, " error code"},
                {48'd0, fault_code}, {48'd0, s[15:2], 2'b00});
        end
        chk(nreads == enr, "R2", {tag, " read count"}, 64'(nreads), 64'(enr));
        for (int i = 0; i < 4; i++) begin
            if (kind == 0 && i == int'(t)) begin
                chk(shadow_desc[i*64 +: 64] == ed && shadow_sel[i*16 +: 16] == s &&
                    shadow_usable[i] == eu, "R9", {tag, " target slot"},
                    shadow_desc[i*64 +: 64], ed);
                chk(shadow_usable[i] == eu, "R3", {tag, " usable flag"},
                    {63'd0, shadow_usable[i]}, {63'd0, eu});
            end else begin
                chk(shadow_desc[i*64 +: 64] == pre_desc[i*64 +: 64] &&
                    shadow_sel[i*16 +: 16] == pre_sel[i*16 +: 16] &&
                    shadow_usable[i] == pre_use[i], "R9", {tag, " other slot kept"},
                    shadow_desc[i*64 +: 64], pre_desc[i*64 +: 64]);
            end
        end
        @(negedge clk);
        chk(!done && !fault && !busy, "R8", {tag, " single pulse"},
            {61'd0, done, fault, busy}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        gdt_tab[0] = '0;
        gdt_tab[1] = mk(32'h0000_0000, 20'hFFFFF, 8'h9A, 4'hC);
        gdt_tab[2] = mk(32'h1234_5600, 20'h0FFFF, 8'h92, 4'h4);
        gdt_tab[3] = mk(32'h0040_0000, 20'h00FFF, 8'hF0, 4'h0);
        gdt_tab[4] = mk(32'h0080_0000, 20'h00FFF, 8'h98, 4'h4);
        gdt_tab[5] = mk(32'h00A0_0000, 20'h00FFF, 8'h12, 4'h0);
        gdt_tab[6] = mk(32'h00C0_0000, 20'h00067, 8'h89, 4'h0);
        gdt_tab[7] = mk(32'hFE00_0000, 20'h00FFF, 8'hF2, 4'h4);
        ldt_tab[0] = mk(32'h0300_0000, 20'h001FF, 8'hD2, 4'h0);
        ldt_tab[1] = mk(32'h0310_0000, 20'h001FF, 8'hFA, 4'h4);
        ldt_tab[2] = mk(32'h0320_0000, 20'h001FF, 8'h10, 4'h0);
        ldt_tab[3] = mk(32'h0330_0000, 20'h001FF, 8'hB2, 4'h0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_rd_valid && shadow_usable == 4'd0, "R8",
            "reset state", {59'd0, busy, done, fault, mem_rd_valid, |shadow_usable}, 64'd0);

        run(16'h0008, 2'd2, 1'b1, "R1 code load");
        run(16'h0010, 2'd0, 1'b1, "R9 data load");
        run(16'h0010, 2'd1, 1'b0, "R5 stack rw");
        run(16'h001B, 2'd3, 1'b0, "R6 rpl3 dpl3");
        run(16'h0018, 2'd1, 1'b0, "R5 stack ro");
        run(16'h0020, 2'd0, 1'b0, "R5 exec-only data");
        run(16'h0020, 2'd2, 1'b0, "R5 exec-only code");
        run(16'h0010, 2'd2, 1'b0, "R5 data into code");
        run(16'h0028, 2'd0, 1'b0, "R7 not present");
        run(16'h0030, 2'd0, 1'b0, "R4 system class");
        run(16'h0013, 2'd0, 1'b0, "R6 dpl below rpl");
        run(16'h003B, 2'd1, 1'b0, "R6 stack equal");
        run(16'h0038, 2'd1, 1'b0, "R6 stack differ");
        run(16'h0040, 2'd0, 1'b0, "R2 global past limit");
        run(16'h0041, 2'd3, 1'b0, "R2 rpl in code");
        run(16'h0000, 2'd0, 1'b0, "R3 null data");
        run(16'h0003, 2'd3, 1'b0, "R3 null data rpl3");
        run(16'h0000, 2'd1, 1'b0, "R3 null stack");
        run(16'h0002, 2'd2, 1'b0, "R3 null code");
        run(16'h0004, 2'd0, 1'b1, "R1 local index0");
        run(16'h000F, 2'd2, 1'b0, "R1 local code");
        run(16'h0014, 2'd3, 1'b0, "R7 local absent");
        run(16'h001D, 2'd1, 1'b0, "R6 local stack");
        run(16'h0024, 2'd0, 1'b0, "R2 local past limit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule